// File: doc/BRIEF.md
# PC Card I/O Window Decoder

This block compares each host I/O port address with two programmable port ranges of a card slot adapter. When an address falls inside an enabled range it signals a hit, says which range matched, and reports the transfer attributes for that range. These are the data width, whether the card chooses the width itself, and the wait-state class. The decode is purely combinational from the stored registers, so an address presented in a cycle is answered in the same cycle.

Software sets up the ranges through a byte-wide register port. Each range has a 16-bit first port and a 16-bit last port, and the last port is inclusive. One shared control byte holds four attribute flags per range: range 0 uses the low nibble and range 1 the high nibble. A separate enable byte switches each range on or off. A register write takes effect on the decode from the next cycle.

Register map (4-bit offset): 0/1 range 0 first port low/high byte, 2/3 range 0 last port low/high byte, 4/5 range 1 first port low/high, 6/7 range 1 last port low/high, 8 attribute byte, 9 enable byte (bit 0 range 0, bit 1 range 1, other bits read 0). Offsets 10 to 15 are unmapped.

Top module: `io_window_decoder`

## Requirements
- R1: After reset every mapped register reads 0, so no range is enabled and every attribute flag is clear.
- R2: A write to offsets 0 to 8 reads back the written byte from the next cycle. Offset 9 reads back only bits [1:0]. Writes to offsets 10 to 15 are ignored, and those offsets read 0.
- R3: A range hits when its enable bit is set and first <= address <= last, with both end ports included.
- R4: A range whose enable bit is clear never hits, whatever its ports hold.
- R5: When both ranges match the same address, range 0 is reported (io_win = 0).
- R6: On a hit, the attribute nibble of the matching range is used: bits [3:0] of offset 8 for range 0, bits [7:4] for range 1. Nibble bit 0 set means io_wide = 1 (16-bit data).
- R7: Nibble bit 1 set drives io_card_sel = 1, and io_wide then follows the card_cs16 input instead of nibble bit 0.
- R8: io_wait = 1 when nibble bit 2 (zero wait) is set, else 2 when nibble bit 3 (extra wait) is set, else 0. Zero wait takes priority.
- R9: With no hit, io_win, io_wide, io_card_sel and io_wait are all 0.
- R10: A range whose first port is above its last port never hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| io_addr | input | 16 | Host I/O port address to decode |
| card_cs16 | input | 1 | Card's own 16-bit request |
| io_hit | output | 1 | Address lies in an enabled range |
| io_win | output | 1 | Index of the matching range |
| io_wide | output | 1 | 16-bit data transfer |
| io_card_sel | output | 1 | Width is chosen by the card |
| io_wait | output | 2 | Wait class: 0 normal, 1 zero wait, 2 extra wait |

## Verification
The decode path and the register write path meet in the same cycle when a write to a port, attribute or enable register coincides with an address that the write is about to move into or out of a range. The bench provokes this by holding a probe address steady across writes that change the ranges, the attribute nibbles and the enables. A behavioural model updates its register copy at the same edge, and it judges that the decode still shows the old setting in the write cycle and the new setting from the next cycle.

// File: rtl/io_window_decoder.sv
module io_window_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] io_addr,
  input  logic        card_cs16,
  output logic        io_hit,
  output logic        io_win,
  output logic        io_wide,
  output logic        io_card_sel,
  output logic [1:0]  io_wait
);

  logic [15:0] first0, last0, first1, last1;
  logic [7:0]  attr;
  logic [1:0]  en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first0 <= '0; last0 <= '0; first1 <= '0; last1 <= '0;
      attr   <= '0; en    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0: first0[7:0]  <= reg_wdata;
        4'd1: first0[15:8] <= reg_wdata;
        4'd2: last0[7:0]   <= reg_wdata;
        4'd3: last0[15:8]  <= reg_wdata;
        4'd4: first1[7:0]  <= reg_wdata;
        4'd5: first1[15:8] <= reg_wdata;
        4'd6: last1[7:0]   <= reg_wdata;
        4'd7: last1[15:8]  <= reg_wdata;
        4'd8: attr         <= reg_wdata;
        4'd9: en           <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = first0[7:0];
      4'd1: reg_rdata = first0[15:8];
      4'd2: reg_rdata = last0[7:0];
      4'd3: reg_rdata = last0[15:8];
      4'd4: reg_rdata = first1[7:0];
      4'd5: reg_rdata = first1[15:8];
      4'd6: reg_rdata = last1[7:0];
      4'd7: reg_rdata = last1[15:8];
      4'd8: reg_rdata = attr;
      4'd9: reg_rdata = {6'b0, en};
      default: reg_rdata = 8'h00;
    endcase
  end

  logic m0, m1;
  logic [3:0] nib;

  assign m0 = en[0] && (io_addr >= first0) && (io_addr <= last0);
  assign m1 = en[1] && (io_addr >= first1) && (io_addr <= last1);

  assign io_hit = m0 | m1;
  assign io_win = !m0 && m1;
  assign nib    = !io_hit ? 4'h0 : (m0 ? attr[3:0] : attr[7:4]);

  assign io_card_sel = nib[1];
  assign io_wide     = nib[1] ? (io_hit && card_cs16) : nib[0];
  assign io_wait     = nib[2] ? 2'd1 : (nib[3] ? 2'd2 : 2'd0);

endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic        reg_we,
  input logic [7:0]  reg_wdata,
  input logic [15:0] io_addr,
  input logic        io_hit,
  input logic        io_win,
  input logic        io_wide,
  input logic        io_card_sel,
  input logic [1:0]  io_wait,
  input logic [15:0] first0,
  input logic [15:0] last0,
  input logic [15:0] first1,
  input logic [15:0] last1,
  input logic [7:0]  attr,
  input logic [1:0]  en
);

  AST_ATTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd8) |=> attr == $past(reg_wdata)); // R2

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_win ? (io_addr >= first1 && io_addr <= last1)
                       : (io_addr >= first0 && io_addr <= last0))); // R3

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> en[io_win]); // R4

  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit && io_win) |-> !(en[0] && io_addr >= first0 && io_addr <= last0)); // R5

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> (!io_win && !io_wide && !io_card_sel && io_wait == 2'd0)); // R9

  AST_NO_BOTH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    io_wait != 2'd3); // R8

endmodule

bind io_window_decoder io_window_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .io_addr(io_addr), .io_hit(io_hit), .io_win(io_win),
  .io_wide(io_wide), .io_card_sel(io_card_sel), .io_wait(io_wait),
  .first0(first0), .last0(last0), .first1(first1), .last1(last1),
  .attr(attr), .en(en)
);

// File: tb/test_io_window_decoder.sv
module test_io_window_decoder;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_we = 0, card_cs16 = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [15:0] io_addr = 0;
  logic io_hit, io_win, io_wide, io_card_sel;
  logic [1:0] io_wait;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  logic [7:0] model [0:15];
  bit done = 0;

  io_window_decoder i_io_window_decoder (.*);

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 16; i++) model[i] <= 8'h00;
    else if (reg_we && reg_addr < 4'd10)
      model[reg_addr] <= (reg_addr == 4'd9) ? (reg_wdata & 8'h03) : reg_wdata;
  end

  task automatic chk(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", t, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      int w;
      int st, sp, nib;
      int e_hit, e_win, e_wide, e_sel, e_wait;
      w = -1;
      for (int k = 1; k >= 0; k--) begin
        st = {model[4*k+1], model[4*k]};
        sp = {model[4*k+3], model[4*k+2]};
        if (model[9][k] && io_addr >= st && io_addr <= sp) w = k;
      end
      e_hit = (w >= 0); e_win = (w == 1);
      nib = (w < 0) ? 0 : ((model[8] >> (4*w)) & 15);
      e_sel = (nib >> 1) & 1;
      e_wide = e_sel ? card_cs16 : (nib & 1);
      if (nib & 4) e_wait = 1; else if (nib & 8) e_wait = 2; else e_wait = 0;
      chk({tag, " rdata"}, reg_rdata, model[reg_addr]);
      chk({tag, " hit/win"}, {io_hit, io_win}, {e_hit[0], e_win[0]});
      chk({tag, " attrs"}, {io_wide, io_card_sel, io_wait},
          {e_wide[0], e_sel[0], e_wait[1:0]});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic setwin(input int k, input logic [15:0] s, input logic [15:0] e);
    wr(4*k,   s[7:0]); wr(4*k+1, s[15:8]);
    wr(4*k+2, e[7:0]); wr(4*k+3, e[15:8]);
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk); io_addr = a;
    card_cs16 = 0; @(negedge clk);
    card_cs16 = 1; @(negedge clk);
  endtask

  task automatic sweep();
    logic [15:0] pts [9] = '{16'h00FF, 16'h0100, 16'h0150, 16'h017F, 16'h0180,
                             16'h01FF, 16'h0200, 16'h02FF, 16'h0300};
    foreach (pts[i]) probe(pts[i]);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    for (int a = 0; a < 16; a++) begin @(negedge clk); reg_addr = a[3:0]; @(negedge clk); end
    tag = "R4";
    setwin(0, 16'h0100, 16'h01FF);
    setwin(1, 16'h0180, 16'h02FF);
    wr(8, 8'hFF);
    sweep();
    tag = "R2";
    for (int a = 0; a < 16; a++) begin
      wr(a[3:0], 8'h5A ^ a[7:0]);
      @(negedge clk); reg_addr = a[3:0]; @(negedge clk);
    end
    setwin(0, 16'h0100, 16'h01FF);
    setwin(1, 16'h0180, 16'h02FF);
    tag = "R3"; wr(9, 8'h01); sweep();
    wr(9, 8'h02); sweep();
    tag = "R5"; wr(9, 8'hFF); sweep();
    tag = "R6";
    for (int n = 0; n < 16; n++) begin
      wr(8, {4'(15 - n), 4'(n)});
      probe(16'h0120); probe(16'h0250);
      if (n == 2) tag = "R7";
      if (n == 4) tag = "R8";
    end
    tag = "R9"; wr(8, 8'hFF); probe(16'h0000); probe(16'hFFFF); probe(16'h0300);
    tag = "R10"; setwin(0, 16'h0400, 16'h03FF); setwin(1, 16'h8000, 16'h7FFF);
    probe(16'h03FF); probe(16'h0400); probe(16'h7FFF); probe(16'h8000);
    tag = "R3"; setwin(0, 16'hFFFF, 16'hFFFF); setwin(1, 16'h0000, 16'h0000);
    probe(16'hFFFF); probe(16'h0000); probe(16'h0001);
    tag = "R5";
    io_addr = 16'h1000;
    setwin(0, 16'h1000, 16'h1000);
    setwin(1, 16'h0F00, 16'h10FF);
    wr(9, 8'h00); wr(9, 8'h02); wr(9, 8'h03); wr(9, 8'h01);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule